// File: doc/BRIEF.md
# Serial Transmit Queue with Delayed Empty Interrupt

This block is the sending half of a classic asynchronous serial port. The CPU writes bytes into a sixteen-entry queue. Whenever the shifter is idle and the queue holds a byte, the block takes the oldest byte and sends it as one 8N1 character on the serial output line, with no further action from the CPU. A baud tick input at sixteen times the bit rate times every bit.

The block also raises an interrupt when the queue is empty, so that software knows it can refill it. A service routine may write one byte and see it move straight into the shifter before it writes the next one. An interrupt raised at that point would look like a new request while the first is still being handled. To prevent this, the first byte written into an empty queue starts a guard interval of one character time, and the interrupt stays low for that interval. The guard is dropped once two bytes have been queued at the same time, and it is armed again each time the queue drains.

Top module: `uart_tx_fifo_holdoff`

## Requirements
- R1: After reset, txd is 1, tx_empty is 1, fifo_full is 0 and irq equals irq_en.
- R2: Once a byte is queued and the shifter is idle, the byte is sent without further input as a 0 start bit, then eight data bits with bit 0 first, then a 1 stop bit. Each bit lasts 16 baud ticks.
- R3: Bytes leave on txd in the order in which their writes were accepted.
- R4: The queue holds at most 16 bytes, and fifo_full is 1 exactly when it holds 16. A write made while it is full is dropped, except in the case covered by R5.
- R5: A write made in the cycle in which a byte moves from a full queue into the shifter is accepted, and fifo_full stays 1.
- R6: tx_empty is 0 from the cycle in which a byte enters the shifter until its stop bit has ended.
- R7: irq is 1 only when irq_en is 1, the queue is empty and no guard interval is running. While irq_en is 0, irq is 0.
- R8: A byte written into an empty queue drives irq to 0 in the next cycle.
- R9: While the guard is armed, a write into an empty queue starts a guard interval of 160 baud ticks. irq stays 0 during that interval, even if the queue empties again.
- R10: Once the queue has held two or more bytes, the guard is disarmed and any running guard interval ends. The next time the queue empties, irq goes to 1 in that same cycle.
- R11: The guard is armed at reset and re-armed each time the queue becomes empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 8 | Byte to queue |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| irq_en | input | 1 | Enables the empty interrupt |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| txd | output | 1 | Serial output, idles high |
| fifo_full | output | 1 | Queue holds 16 bytes |
| tx_empty | output | 1 | Shifter idle, no character in flight |
| irq | output | 1 | Queue-empty interrupt after the guard gating |

## Verification
Two events can fall in the same cycle: a CPU write that meets a full queue, and the move of the head byte into the shifter. The bench fills the queue while a character is in flight. It then watches at every negative edge for tx_empty going high while fifo_full is still high, and drives a write in exactly that cycle. The write is judged correct if fifo_full stays high and the extra byte later appears on txd in its place in the order, as decoded by the serial monitor against the scoreboard queue.

// File: rtl/uart_tx_fifo_holdoff.sv
module uart_tx_fifo_holdoff #(
  parameter int DEPTH      = 16,
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              irq_en,
  input  logic              baud_tick,
  output logic              txd,
  output logic              fifo_full,
  output logic              tx_empty,
  output logic              irq
);
  localparam int PTR_W      = $clog2(DEPTH);
  localparam int CNT_W      = $clog2(DEPTH + 1);
  localparam int FRAME_W    = DATA_W + 2;
  localparam int BIT_W      = $clog2(FRAME_W);
  localparam int OS_W       = $clog2(OVERSAMPLE);
  localparam int HOLD_TICKS = FRAME_W * OVERSAMPLE;
  localparam int HOLD_W     = $clog2(HOLD_TICKS + 1);

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0]   wp, rp;
  logic [CNT_W-1:0]   count, count_nxt;
  logic               busy;
  logic [FRAME_W-1:0] frame;
  logic [BIT_W-1:0]   bit_idx;
  logic [OS_W-1:0]    tick_cnt;
  logic               armed, hold_active;
  logic [HOLD_W-1:0]  hold_cnt;
  logic               load, wr_ok, q_empty;

  assign q_empty   = (count == '0);
  assign fifo_full = (count == CNT_W'(DEPTH));
  assign load      = !busy && !q_empty;
  assign wr_ok     = wr_en && (!fifo_full || load);
  assign count_nxt = count + CNT_W'(wr_ok) - CNT_W'(load);

  assign txd      = busy ? frame[0] : 1'b1;
  assign tx_empty = !busy;
  assign irq      = irq_en && q_empty && !hold_active;

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (load)  rp <= rp + 1'b1;
      count <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      frame    <= '1;
      bit_idx  <= '0;
      tick_cnt <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      frame    <= {1'b1, mem[rp], 1'b0};
      bit_idx  <= '0;
      tick_cnt <= '0;
    end else if (busy && baud_tick) begin
      if (tick_cnt == OS_W'(OVERSAMPLE - 1)) begin
        tick_cnt <= '0;
        frame    <= {1'b1, frame[FRAME_W-1:1]};
        if (bit_idx == BIT_W'(FRAME_W - 1)) busy <= 1'b0;
        else bit_idx <= bit_idx + 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed       <= 1'b1;
      hold_active <= 1'b0;
      hold_cnt    <= '0;
    end else if (count_nxt >= CNT_W'(2)) begin
      armed       <= 1'b0;
      hold_active <= 1'b0;
    end else begin
      if (count_nxt == '0) armed <= 1'b1;
      if (armed && wr_ok && q_empty) begin
        hold_active <= 1'b1;
        hold_cnt    <= HOLD_W'(HOLD_TICKS);
      end else if (hold_active && baud_tick) begin
        if (hold_cnt == HOLD_W'(1)) hold_active <= 1'b0;
        hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1) || (count + 1'b1 == $past(count))); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && !load) |=> fifo_full); // R4
  AST_FULL_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && load) |=> fifo_full); // R5
  AST_AUTO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !q_empty) |=> (!tx_empty && !txd)); // R2
  AST_FIRST_BYTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && q_empty) |=> !irq); // R8
  AST_GUARD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en && q_empty) |=> (hold_active && !irq)); // R9
  AST_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= CNT_W'(2)) |-> (!hold_active && !armed)); // R10
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> (armed || count != '0)); // R11
endmodule

// File: tb/tb_uart_tx_fifo_holdoff.sv
module tb_uart_tx_fifo_holdoff;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_en = 1'b0;
  logic       irq_en = 1'b1;
  logic       baud_tick = 1'b0;
  logic       txd, fifo_full, tx_empty, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  uart_tx_fifo_holdoff dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en),
    .irq_en(irq_en), .baud_tick(baud_tick), .txd(txd),
    .fifo_full(fifo_full), .tx_empty(tx_empty), .irq(irq)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    baud_tick = ~baud_tick;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_now(input logic [7:0] b);
    if (!fifo_full || tx_empty) exp_q.push_back(b);
    wr_data = b;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    write_now(b);
  endtask

  initial begin : monitor
    logic [7:0] got;
    logic [7:0] want;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd == 1'b0) begin
        repeat (16) @(negedge clk);
        check("R2 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (32) @(negedge clk);
          got[i] = txd;
        end
        repeat (32) @(negedge clk);
        check("R2 stop bit", txd, 1);
        check("R6 busy during stop", tx_empty, 0);
        if (exp_q.size() == 0) begin
          check("R3 unexpected byte", got, 'h100);
        end else begin
          want = exp_q.pop_front();
          check("R3 byte order / R2 LSB first", got, want);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int n;
    repeat (4) @(negedge clk);
    check("R1 txd", txd, 1);
    check("R1 tx_empty", tx_empty, 1);
    check("R1 fifo_full", fifo_full, 0);
    check("R1 irq", irq, 1);
    rst_n = 1'b1;
    @(negedge clk);
    irq_en = 1'b0;
    @(negedge clk);
    check("R7 irq disabled", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    check("R7 irq enabled empty", irq, 1);

    // first byte into empty queue: guard interval
    write_byte(8'hA5);
    check("R8 irq after first byte", irq, 0);
    @(negedge clk);
    check("R6 shifter busy", tx_empty, 0);
    check("R9 irq held while queue empty", irq, 0);
    repeat (296) @(negedge clk);
    check("R9 irq still held at 150 ticks", irq, 0);
    repeat (40) @(negedge clk);
    check("R9 irq after guard", irq, 1);
    wait (tx_empty == 1'b1);
    @(negedge clk);

    // two resident bytes disarm the guard
    write_byte(8'h01);
    write_byte(8'h80);
    write_byte(8'hFF);
    check("R10 irq while queued", irq, 0);
    n = 0;
    while (n < 2) begin
      @(negedge clk);
      if (tx_empty) n++;
    end
    check("R10 irq before last move", irq, 0);
    @(negedge clk);
    check("R10 irq immediate on empty", irq, 1);
    check("R6 shifter reloaded", tx_empty, 0);
    wait (tx_empty == 1'b1);
    @(negedge clk);

    // guard re-armed after draining
    write_byte(8'h3C);
    @(negedge clk);
    check("R11 guard re-armed", irq, 0);
    wait (tx_empty == 1'b1);
    @(negedge clk);

    // fill beyond capacity
    for (int i = 0; i < 18; i++) write_byte(8'h40 + 8'(i));
    check("R4 full flag", fifo_full, 1);
    check("R4 queued count", exp_q.size(), 17);
    // write in the same cycle as the move into the shifter
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    check("R5 still full at move", fifo_full, 1);
    write_now(8'h00);
    check("R5 full after same-cycle write", fifo_full, 1);
    check("R5 write accepted", exp_q.size(), 17);

    n = 0;
    while ((exp_q.size() != 0 || !tx_empty) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (40) @(negedge clk);
    check("R3 all bytes sent", exp_q.size(), 0);
    check("R4 not full after drain", fifo_full, 0);
    check("R10 irq after drain", irq, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule